// File: doc/BRIEF.md
# Skip Condition Evaluator

This block decides whether a skip-group instruction word causes the next instruction to be passed over, and it computes the following program counter value. The low-order bits of the word each select one machine condition. These conditions are the accumulator sign, the accumulator's least significant bit, a nonzero accumulator, four sense switches and the carry flag. One polarity bit picks how the selected conditions combine. With the bit set, the block skips when any selected condition holds. With the bit clear, it skips only when none of them holds.

The skip decision is combinational, from the word and the current machine state. The next program counter is registered. On every clock edge it takes the presented program counter plus two on a skip, or plus one otherwise, and it wraps at the counter width. A word outside the skip group never skips and gives plus one.

Top module: `skip_eval_top`

## Requirements
- R1: A word whose bits 15..10 are not exactly `100000` (binary) gives `skip`=0, and the registered next PC is PC+1.
- R2: Octal word 100000 (no condition selected, polarity 0) always skips.
- R3: Octal word 101000 (no condition selected, polarity 1) never skips.
- R4: Bit 8 selects the accumulator sign (`accIn[15]`). Octal 101400 skips when the sign is 1. Octal 100400 skips when the sign is 0.
- R5: Bit 6 selects `accIn[0]`. Octal 101100 skips when it is 1. Octal 100100 skips when it is 0.
- R6: Bit 5 selects "accumulator nonzero". Octal 101040 skips when `accIn`≠0. Octal 100040 skips when `accIn`=0.
- R7: Bits 4, 3, 2 and 1 select switches 1, 2, 3 and 4, which are `swOn[0]`..`swOn[3]`. With prefix 101 the word skips when the selected switch is on. With prefix 100 it skips when the switch is off. Octal 101036 skips if any switch is on, and octal 100036 skips only if no switch is on.
- R8: Bit 0 selects the carry. Octal 101001 skips when `carryIn`=1. Octal 100001 skips when `carryIn`=0.
- R9: Bit 9 is the polarity. When it is 1, skip is the OR of all selected conditions. When it is 0, skip is the NOR of them.
- R10: On each rising clock edge out of reset, `nextPc` loads `pcIn`+2 if `skip` is 1 and `pcIn`+1 if it is 0, modulo 2^PC_W.
- R11: While `rstN` is low, `nextPc` is 0.
- R12: Bit 7 selects no condition and has no effect on `skip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instrWord | input | 16 | Instruction word under evaluation |
| accIn | input | 16 | Accumulator value |
| carryIn | input | 1 | Carry flag |
| swOn | input | 4 | Sense switch levels, bit 0 = switch 1 |
| pcIn | input | PC_W | Current program counter |
| skip | output | 1 | Combinational skip decision |
| nextPc | output | PC_W | Registered next program counter |

## Verification
Two functions can act in the same cycle: a true skip decision and the wrap of the program counter. The bench presents the all-ones and all-ones-minus-one counter values with words that skip and words that do not. The expected registered value then lands on 0 or 1. A behavioural reference model computes the skip from the requirements. It compares both outputs on every clock, over directed words and a long run of random words drawn mostly from the skip group.

// File: rtl/skip_eval_pkg.sv
package skip_eval_pkg;
  localparam int WORD_W  = 16;
  localparam int NUM_SW  = 4;
  localparam int COND_W  = 9;

  typedef struct packed {
    logic enable;
    logic skip;
  } skipStrobe_t;
endpackage

// File: rtl/skip_eval_ctrl.sv
module skip_eval_ctrl
  import skip_eval_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [ACC_W-1:0]  accIn,
  input  logic              carryIn,
  input  logic [NUM_SW-1:0] swOn,
  output skipStrobe_t       strobe
);
  localparam int POL_BIT  = 9;
  localparam int SIGN_BIT = 8;
  localparam int LSB_BIT  = 6;
  localparam int NZ_BIT   = 5;

  logic [COND_W-1:0] condVec;
  logic [COND_W-1:0] selVec;
  logic              groupHit;
  logic              anyTrue;

  always_comb begin
    condVec           = '0;
    condVec[0]        = carryIn;
    condVec[NZ_BIT]   = |accIn;
    condVec[LSB_BIT]  = accIn[0];
    condVec[SIGN_BIT] = accIn[ACC_W-1];
    for (int i = 0; i < NUM_SW; i++) begin
      condVec[NUM_SW - i] = swOn[i];
    end
  end

  assign groupHit = (instrWord[WORD_W-1:POL_BIT+1] == 6'b100000);
  assign selVec   = instrWord[COND_W-1:0] & 9'b1_0111_1111;
  assign anyTrue  = |(selVec & condVec);

  assign strobe.enable = groupHit;
  assign strobe.skip   = groupHit & (instrWord[POL_BIT] ? anyTrue : ~anyTrue);

  a_r1_outside_no_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord[15:10] != 6'b100000) |-> !strobe.skip);
  a_r2_always_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord == 16'o100000) |-> strobe.skip);
  a_r3_never_skip: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord == 16'o101000) |-> !strobe.skip);
  a_r8_carry_set: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord == 16'o101001) |-> (strobe.skip == carryIn));
  a_r4_sign_plus: assert property (@(posedge clk) disable iff (!rstN)
    (instrWord == 16'o100400) |-> (strobe.skip == !accIn[ACC_W-1]));
endmodule

// File: rtl/skip_eval_dp.sv
module skip_eval_dp
  import skip_eval_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  skipStrobe_t     strobe,
  input  logic [PC_W-1:0] pcIn,
  output logic [PC_W-1:0] nextPc
);
  localparam logic [PC_W-1:0] STEP_ONE = PC_W'(1);
  localparam logic [PC_W-1:0] STEP_TWO = PC_W'(2);

  logic [PC_W-1:0] pcQ;
  logic [PC_W-1:0] stepAmt;
  logic            runSeen;

  assign stepAmt = strobe.skip ? STEP_TWO : STEP_ONE;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= '0;
      runSeen <= 1'b0;
    end else begin
      pcQ     <= pcIn + stepAmt;
      runSeen <= 1'b1;
    end
  end

  assign nextPc = pcQ;

  a_r10_pc_step: assert property (@(posedge clk) disable iff (!rstN)
    runSeen |-> (nextPc == $past(pcIn) + ($past(strobe.skip) ? STEP_TWO : STEP_ONE)));
  a_r1_disabled_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.enable |-> !strobe.skip);
endmodule

// File: rtl/skip_eval_top.sv
module skip_eval_top
  import skip_eval_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       instrWord,
  input  logic [15:0]       accIn,
  input  logic              carryIn,
  input  logic [3:0]        swOn,
  input  logic [PC_W-1:0]   pcIn,
  output logic              skip,
  output logic [PC_W-1:0]   nextPc
);
  skipStrobe_t strobe;

  skip_eval_ctrl #(.ACC_W(16)) uCtrl (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .accIn(accIn),
    .carryIn(carryIn), .swOn(swOn), .strobe(strobe)
  );

  skip_eval_dp #(.PC_W(PC_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcIn(pcIn), .nextPc(nextPc)
  );

  assign skip = strobe.skip;

  a_r11_reset_pc: assert property (@(posedge clk)
    !rstN |=> (nextPc == '0));
endmodule

// File: tb/tb_skip_eval_top.sv
`timescale 1ns/1ps
module tb_skip_eval_top;
  logic        clk = 0;
  logic        rstN = 0;
  logic [15:0] instrWord = 0;
  logic [15:0] accIn = 0;
  logic        carryIn = 0;
  logic [3:0]  swOn = 0;
  logic [15:0] pcIn = 0;
  logic        skip;
  logic [15:0] nextPc;
  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  skip_eval_top #(.PC_W(16)) dut (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .accIn(accIn),
    .carryIn(carryIn), .swOn(swOn), .pcIn(pcIn), .skip(skip), .nextPc(nextPc)
  );

  function automatic bit refSkip(input logic [15:0] w, input logic [15:0] a,
                                 input logic c, input logic [3:0] s);
    bit any = 0;
    if (w[15:10] != 6'b100000) return 0;
    if (w[8] && a[15]) any = 1;
    if (w[6] && a[0]) any = 1;
    if (w[5] && (a != 0)) any = 1;
    for (int k = 0; k < 4; k++) if (w[4-k] && s[k]) any = 1;
    if (w[0] && c) any = 1;
    return w[9] ? any : !any;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [15:0] w, input logic [15:0] a,
                      input logic c, input logic [3:0] s, input logic [15:0] pc);
    bit e;
    @(negedge clk);
    instrWord = w; accIn = a; carryIn = c; swOn = s; pcIn = pc;
    e = refSkip(w, a, c, s);
    #1 check({tag, " skip"}, {31'b0, skip}, {31'b0, e});
    @(posedge clk);
    #1 check({tag, " R10 nextPc"}, {16'b0, nextPc}, {16'b0, 16'(pc + (e ? 16'd2 : 16'd1))});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R11 reset", {16'b0, nextPc}, 32'h0);
    @(negedge clk) rstN = 1;
    step("R1 nongroup", 16'o141000, 16'h8001, 1, 4'hF, 16'h0100);
    step("R1 nongroup2", 16'o000000, 16'h0000, 0, 4'h0, 16'h0200);
    step("R2 always", 16'o100000, 16'h1234, 1, 4'hF, 16'h0300);
    step("R3 never", 16'o101000, 16'hFFFF, 1, 4'hF, 16'h0400);
    step("R4 minus", 16'o101400, 16'h8000, 0, 4'h0, 16'h0010);
    step("R4 minus0", 16'o101400, 16'h7FFF, 0, 4'h0, 16'h0010);
    step("R4 plus", 16'o100400, 16'h7FFF, 0, 4'h0, 16'h0010);
    step("R4 plus1", 16'o100400, 16'h8000, 0, 4'h0, 16'h0010);
    step("R5 lsb1", 16'o101100, 16'h0001, 0, 4'h0, 16'h0020);
    step("R5 lsb0", 16'o100100, 16'h0002, 0, 4'h0, 16'h0020);
    step("R5 lsb0n", 16'o100100, 16'h0003, 0, 4'h0, 16'h0020);
    step("R6 nz", 16'o101040, 16'h0400, 0, 4'h0, 16'h0030);
    step("R6 zero", 16'o100040, 16'h0000, 0, 4'h0, 16'h0030);
    step("R6 zero_n", 16'o100040, 16'h0001, 0, 4'h0, 16'h0030);
    step("R7 sw1on", 16'o101020, 16'h0000, 0, 4'b0001, 16'h0040);
    step("R7 sw1off", 16'o100020, 16'h0000, 0, 4'b1110, 16'h0040);
    step("R7 sw4on", 16'o101002, 16'h0000, 0, 4'b1000, 16'h0040);
    step("R7 sw4wrong", 16'o101002, 16'h0000, 0, 4'b0001, 16'h0040);
    step("R7 any", 16'o101036, 16'h0000, 0, 4'b0100, 16'h0040);
    step("R7 none", 16'o100036, 16'h0000, 0, 4'b0000, 16'h0040);
    step("R7 none_n", 16'o100036, 16'h0000, 0, 4'b0010, 16'h0040);
    step("R8 cset", 16'o101001, 16'h0000, 1, 4'h0, 16'h0050);
    step("R8 cclr", 16'o100001, 16'h0000, 0, 4'h0, 16'h0050);
    step("R8 cclr_n", 16'o100001, 16'h0000, 1, 4'h0, 16'h0050);
    step("R9 or", 16'o101441, 16'h0000, 1, 4'h0, 16'h0060);
    step("R9 nor", 16'o100441, 16'h0000, 1, 4'h0, 16'h0060);
    step("R12 bit7", 16'o100200, 16'hFFFF, 1, 4'hF, 16'h0070);
    step("R12 bit7p", 16'o101200, 16'hFFFF, 1, 4'hF, 16'h0070);
    step("R10 wrapskip", 16'o100000, 16'h0, 0, 4'h0, 16'hFFFF);
    step("R10 wrapskip2", 16'o100000, 16'h0, 0, 4'h0, 16'hFFFE);
    step("R10 wrapnoskip", 16'o101000, 16'h0, 0, 4'h0, 16'hFFFF);
    for (int n = 0; n < 400; n++) begin
      logic [15:0] w = 16'($urandom);
      if (n % 8 != 0) w[15:10] = 6'b100000;
      step("R9 random", w, 16'($urandom), 1'($urandom), 4'($urandom), 16'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule